// File: doc/BRIEF.md
# DSI PLL Configuration Word Calculator

This block turns two numbers into the settings for a display serial link PLL. The two numbers are a reference clock frequency in kHz and a wanted per-lane bit rate in kbit/s. It produces a packed 16-bit configuration word, the PLL rate that word actually gives, and a 6-bit low-power clock divider field. A controller pulses `start` with both numbers on the inputs. It waits for the one-cycle `done` pulse and then reads the results. The results stay on the outputs until the next accepted start.

The arithmetic is done step by step rather than in wide combinational logic. A scan unit searches for the predivider by adding a fixed step to a running threshold. A shift-add multiplier handles every product. A single restoring divider handles every quotient: the rounded-up multiplier, the truncated PLL rate and the rounded-up low-power divider. A controlling state machine runs the steps in order: `ST_IDLE` goes to `ST_SCAN` on start (or to `ST_FAULT` when the reference is zero). Then `ST_SCAN` goes to `ST_MULA`, then `ST_DIVA`, `ST_MULB`, `ST_DIVB`, `ST_DIVC`, and finally `ST_DONE`. Each step moves on when its arithmetic unit reports completion. `ST_DONE` and `ST_FAULT` each last one cycle and then return to `ST_IDLE`.

Top module: `dsi_pll_calc`

## Requirements
- R1: When idle (busy and done both low), a start with a nonzero reference raises busy on the next cycle. done is a single-cycle pulse with busy low in that cycle, and the cycle after done has done low.
- R2: The predivider P is floor(reference/5000) limited to the range 1..31. It appears in cfg_word bits 12:8.
- R3: The multiplier M is ceiling(rate × P / reference). It appears in cfg_word bits 7:0.
- R4: When M exceeds 255, ovf is set and bits 7:0 hold 255. Otherwise ovf is low.
- R5: pll_kbps equals floor(reference × M' / P). M' is the field value from bits 7:0, with a field of zero taken as 1.
- R6: cfg_word bits 15:14 hold the range code taken from pll_kbps: 3 when at least 501000, 2 when at least 251000, 1 when at least 126000, 0 otherwise. Bit 13 is zero.
- R7: lp_div_field equals (ceiling(pll_kbps / 80000) − 1) modulo 64.
- R8: A start with a zero reference sets err, gives done on the next cycle without raising busy, and clears cfg_word, pll_kbps, lp_div_field and ovf. A later valid run clears err.
- R9: A start while busy is ignored: the run in progress completes with results for the inputs it started with.
- R10: After reset, busy, done, err and ovf are low and cfg_word, pll_kbps and lp_div_field are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Begin a calculation (accepted only when idle) |
| ref_khz | input | REF_W | Reference clock frequency in kHz |
| rate_kbps | input | RATE_W | Wanted per-lane bit rate in kbit/s |
| busy | output | 1 | Calculation in progress |
| done | output | 1 | One-cycle completion pulse |
| err | output | 1 | Last request had a zero reference |
| ovf | output | 1 | Multiplier saturated at 255 |
| cfg_word | output | 16 | Packed range code, predivider and multiplier |
| pll_kbps | output | REF_W+8 | Resulting PLL rate in kbit/s |
| lp_div_field | output | 6 | Low-power clock divider field |

## Verification
The assertions take for granted that start is raised only from idle, or else ignored. They also take for granted that the internal datapath is wide enough for rate × 31 + reference and for reference × 255, so no product wraps. With the port widths fixed, that width follows from the parameters. The divider checks assume a nonzero divisor at every launch. The fault path makes that true by keeping a zero reference away from the division. The stimulus sweeps references across the predivider boundaries up to the largest port value, together with rates from zero to the port maximum. It raises start only when the block is idle, except in one run that deliberately pulses start mid-calculation.

// File: rtl/dpc_pkg.sv
package dpc_pkg;

    localparam int unsigned PD_W       = 5;
    localparam int unsigned MF_W       = 8;
    localparam int unsigned LPF_W      = 6;
    localparam int unsigned LP_CLK_KHZ = 10000;
    localparam int unsigned LP_BITS    = 8;
    localparam int unsigned LP_DEN     = LP_CLK_KHZ * LP_BITS;

    localparam int unsigned RC3_KBPS = 501000;
    localparam int unsigned RC2_KBPS = 251000;
    localparam int unsigned RC1_KBPS = 126000;

    typedef enum logic [3:0] {
        ST_IDLE,
        ST_SCAN,
        ST_MULA,
        ST_DIVA,
        ST_MULB,
        ST_DIVB,
        ST_DIVC,
        ST_DONE,
        ST_FAULT
    } dpc_state_e;

    function automatic logic [1:0] range_code(input logic [31:0] kbps);
        if (kbps >= RC3_KBPS)      return 2'd3;
        else if (kbps >= RC2_KBPS) return 2'd2;
        else if (kbps >= RC1_KBPS) return 2'd1;
        else                       return 2'd0;
    endfunction

endpackage

// File: rtl/dpc_prediv_scan.sv
module dpc_prediv_scan #(
    parameter int REF_W   = 20,
    parameter int PD_W    = 5,
    parameter int MIN_KHZ = 5000,
    parameter int PMAX    = 31
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             go,
    input  logic [REF_W-1:0] ref_khz,
    output logic             done,
    output logic [PD_W-1:0]  pdiv
);

    localparam int THR_W = $clog2(MIN_KHZ * (PMAX + 2)) + 1;
    localparam int CMP_W = (REF_W > THR_W) ? REF_W : THR_W;

    logic             running;
    logic [PD_W-1:0]  p_q;
    logic [CMP_W-1:0] thr_q;
    logic [CMP_W-1:0] ref_q;
    logic             step_ok;

    assign step_ok = (ref_q >= thr_q) && (p_q < PD_W'(PMAX));
    assign pdiv    = p_q;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            running <= 1'b0;
            done    <= 1'b0;
            p_q     <= PD_W'(1);
            thr_q   <= '0;
            ref_q   <= '0;
        end else begin
            done <= 1'b0;
            if (go) begin
                running <= 1'b1;
                p_q     <= PD_W'(1);
                thr_q   <= CMP_W'(2 * MIN_KHZ);
                ref_q   <= CMP_W'(ref_khz);
            end else if (running) begin
                if (step_ok) begin
                    p_q   <= p_q + PD_W'(1);
                    thr_q <= thr_q + CMP_W'(MIN_KHZ);
                end else begin
                    running <= 1'b0;
                    done    <= 1'b1;
                end
            end
        end
    end

    // R2: the chosen predivider never exceeds reference / minimum
    p_floor_r2: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> (p_q == PD_W'(1)) ||
                 (ref_q >= CMP_W'(MIN_KHZ) * CMP_W'(p_q)));

    // R2: the search stops only at the clamp or when the next step fails
    p_stop_r2: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> (p_q == PD_W'(PMAX)) ||
                 (ref_q < CMP_W'(MIN_KHZ) * (CMP_W'(p_q) + CMP_W'(1))));

endmodule

// File: rtl/dpc_seq_mult.sv
module dpc_seq_mult #(
    parameter int A_W = 29,
    parameter int B_W = 8
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           go,
    input  logic [A_W-1:0] a,
    input  logic [B_W-1:0] b,
    output logic           done,
    output logic [A_W-1:0] prod
);

    localparam int CNT_W = $clog2(B_W + 1);

    logic             running;
    logic [A_W-1:0]   acc_q;
    logic [A_W-1:0]   ash_q;
    logic [B_W-1:0]   bsh_q;
    logic [CNT_W-1:0] cnt_q;

    assign prod = acc_q;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            running <= 1'b0;
            done    <= 1'b0;
            acc_q   <= '0;
            ash_q   <= '0;
            bsh_q   <= '0;
            cnt_q   <= '0;
        end else begin
            done <= 1'b0;
            if (go) begin
                running <= 1'b1;
                acc_q   <= '0;
                ash_q   <= a;
                bsh_q   <= b;
                cnt_q   <= CNT_W'(B_W);
            end else if (running) begin
                if (bsh_q[0]) acc_q <= acc_q + ash_q;
                ash_q <= ash_q << 1;
                bsh_q <= bsh_q >> 1;
                cnt_q <= cnt_q - CNT_W'(1);
                if (cnt_q == CNT_W'(1)) begin
                    running <= 1'b0;
                    done    <= 1'b1;
                end
            end
        end
    end

    // R1: completion of a product is a single-cycle event
    p_mul_pulse_r1: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    // R5: a zero multiplicand gives a zero product
    p_mul_zero_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (go && a == '0) |=> (running && acc_q == '0));

endmodule

// File: rtl/dpc_seq_div.sv
module dpc_seq_div #(
    parameter int DW = 29
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          go,
    input  logic [DW-1:0] dividend,
    input  logic [DW-1:0] divisor,
    output logic          done,
    output logic [DW-1:0] quot
);

    localparam int CNT_W = $clog2(DW + 1);

    logic             running;
    logic [DW-1:0]    rem_q;
    logic [DW-1:0]    quo_q;
    logic [DW-1:0]    dvs_q;
    logic [CNT_W-1:0] cnt_q;
    logic [DW:0]      shifted;
    logic [DW+1:0]    diff;

    assign shifted = {rem_q, quo_q[DW-1]};
    assign diff    = {1'b0, shifted} - {2'b00, dvs_q};
    assign quot    = quo_q;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            running <= 1'b0;
            done    <= 1'b0;
            rem_q   <= '0;
            quo_q   <= '0;
            dvs_q   <= '0;
            cnt_q   <= '0;
        end else begin
            done <= 1'b0;
            if (go) begin
                running <= 1'b1;
                rem_q   <= '0;
                quo_q   <= dividend;
                dvs_q   <= divisor;
                cnt_q   <= CNT_W'(DW);
            end else if (running) begin
                if (diff[DW+1]) begin
                    rem_q <= shifted[DW-1:0];
                    quo_q <= {quo_q[DW-2:0], 1'b0};
                end else begin
                    rem_q <= diff[DW-1:0];
                    quo_q <= {quo_q[DW-2:0], 1'b1};
                end
                cnt_q <= cnt_q - CNT_W'(1);
                if (cnt_q == CNT_W'(1)) begin
                    running <= 1'b0;
                    done    <= 1'b1;
                end
            end
        end
    end

    // R8: no division is ever launched with a zero divisor
    p_div_nz_r8: assert property (@(posedge clk) disable iff (!rst_n)
        go |-> divisor != '0);

    // R3: the partial remainder stays below the divisor
    p_rem_bound_r3: assert property (@(posedge clk) disable iff (!rst_n)
        running |-> rem_q < dvs_q);

endmodule

// File: rtl/dsi_pll_calc.sv
module dsi_pll_calc #(
    parameter int REF_W      = 20,
    parameter int RATE_W     = 20,
    parameter int MIN_IF_KHZ = 5000,
    parameter int PDIV_MAX   = 31
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                start,
    input  logic [REF_W-1:0]    ref_khz,
    input  logic [RATE_W-1:0]   rate_kbps,
    output logic                busy,
    output logic                done,
    output logic                err,
    output logic                ovf,
    output logic [15:0]         cfg_word,
    output logic [REF_W+7:0]    pll_kbps,
    output logic [5:0]          lp_div_field
);

    import dpc_pkg::*;

    localparam int PLL_W = REF_W + MF_W;
    localparam int PROD1 = RATE_W + PD_W + 1;
    localparam int DW    = ((PROD1 > PLL_W) ? PROD1 : PLL_W) + 1;

    dpc_state_e state, nxt;

    logic [REF_W-1:0]  ref_q;
    logic [RATE_W-1:0] rate_q;
    logic [PD_W-1:0]   pd_q;
    logic [MF_W-1:0]   mf_q;
    logic              ovf_q;
    logic [PLL_W-1:0]  pll_q;

    logic [15:0]       res_word;
    logic [PLL_W-1:0]  res_pll;
    logic [LPF_W-1:0]  res_lp;
    logic              res_ovf;
    logic              res_err;

    logic              scan_go, scan_done;
    logic [PD_W-1:0]   scan_p;
    logic              mul_go, mul_done;
    logic [DW-1:0]     mul_a, mul_prod;
    logic [MF_W-1:0]   mul_b;
    logic              div_go, div_done;
    logic [DW-1:0]     div_n, div_d, div_q;

    logic              m_big;
    logic [MF_W-1:0]   m_sat;
    logic [MF_W-1:0]   m_eff;
    logic              accept;

    assign accept = (state == ST_IDLE) && start;
    assign scan_go = accept && (ref_khz != '0);

    dpc_prediv_scan #(
        .REF_W  (REF_W),
        .PD_W   (PD_W),
        .MIN_KHZ(MIN_IF_KHZ),
        .PMAX   (PDIV_MAX)
    ) u_scan (
        .clk    (clk),
        .rst_n  (rst_n),
        .go     (scan_go),
        .ref_khz(ref_khz),
        .done   (scan_done),
        .pdiv   (scan_p)
    );

    dpc_seq_mult #(
        .A_W(DW),
        .B_W(MF_W)
    ) u_mult (
        .clk  (clk),
        .rst_n(rst_n),
        .go   (mul_go),
        .a    (mul_a),
        .b    (mul_b),
        .done (mul_done),
        .prod (mul_prod)
    );

    dpc_seq_div #(
        .DW(DW)
    ) u_div (
        .clk     (clk),
        .rst_n   (rst_n),
        .go      (div_go),
        .dividend(div_n),
        .divisor (div_d),
        .done    (div_done),
        .quot    (div_q)
    );

    // multiplier field saturation and zero substitution
    always_comb begin
        m_big = div_q > DW'(255);
        m_sat = m_big ? 8'hFF : div_q[MF_W-1:0];
        m_eff = (m_sat == '0) ? MF_W'(1) : m_sat;
    end

    // operand routing and launch of the shared arithmetic units
    always_comb begin
        mul_go = 1'b0;
        mul_a  = '0;
        mul_b  = '0;
        div_go = 1'b0;
        div_n  = '0;
        div_d  = '0;
        unique case (state)
            ST_SCAN: if (scan_done) begin
                mul_go = 1'b1;
                mul_a  = DW'(rate_q);
                mul_b  = MF_W'(scan_p);
            end
            ST_MULA: if (mul_done) begin
                div_go = 1'b1;
                div_n  = mul_prod + DW'(ref_q) - DW'(1);
                div_d  = DW'(ref_q);
            end
            ST_DIVA: if (div_done) begin
                mul_go = 1'b1;
                mul_a  = DW'(ref_q);
                mul_b  = m_eff;
            end
            ST_MULB: if (mul_done) begin
                div_go = 1'b1;
                div_n  = mul_prod;
                div_d  = DW'(pd_q);
            end
            ST_DIVB: if (div_done) begin
                div_go = 1'b1;
                div_n  = div_q + DW'(LP_DEN - 1);
                div_d  = DW'(LP_DEN);
            end
            default: ;
        endcase
    end

    // next-state decision
    always_comb begin
        nxt = state;
        unique case (state)
            ST_IDLE:  if (start) nxt = (ref_khz == '0) ? ST_FAULT : ST_SCAN;
            ST_SCAN:  if (scan_done) nxt = ST_MULA;
            ST_MULA:  if (mul_done)  nxt = ST_DIVA;
            ST_DIVA:  if (div_done)  nxt = ST_MULB;
            ST_MULB:  if (mul_done)  nxt = ST_DIVB;
            ST_DIVB:  if (div_done)  nxt = ST_DIVC;
            ST_DIVC:  if (div_done)  nxt = ST_DONE;
            ST_DONE:  nxt = ST_IDLE;
            ST_FAULT: nxt = ST_IDLE;
            default:  nxt = ST_IDLE;
        endcase
    end

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) state <= ST_IDLE;
        else        state <= nxt;
    end

    // datapath and result registers
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ref_q    <= '0;
            rate_q   <= '0;
            pd_q     <= PD_W'(1);
            mf_q     <= '0;
            ovf_q    <= 1'b0;
            pll_q    <= '0;
            res_word <= '0;
            res_pll  <= '0;
            res_lp   <= '0;
            res_ovf  <= 1'b0;
            res_err  <= 1'b0;
        end else begin
            if (accept) begin
                ref_q  <= ref_khz;
                rate_q <= rate_kbps;
                if (ref_khz == '0) begin
                    res_word <= '0;
                    res_pll  <= '0;
                    res_lp   <= '0;
                    res_ovf  <= 1'b0;
                    res_err  <= 1'b1;
                end
            end
            if (state == ST_SCAN && scan_done) pd_q <= scan_p;
            if (state == ST_DIVA && div_done) begin
                mf_q  <= m_sat;
                ovf_q <= m_big;
            end
            if (state == ST_DIVB && div_done) pll_q <= div_q[PLL_W-1:0];
            if (state == ST_DIVC && div_done) begin
                res_word <= {range_code(32'(pll_q)), 1'b0, pd_q, mf_q};
                res_pll  <= pll_q;
                res_lp   <= div_q[LPF_W-1:0] - LPF_W'(1);
                res_ovf  <= ovf_q;
                res_err  <= 1'b0;
            end
        end
    end

    // output decode
    always_comb begin
        busy         = (state != ST_IDLE) && (state != ST_DONE) &&
                       (state != ST_FAULT);
        done         = (state == ST_DONE) || (state == ST_FAULT);
        err          = res_err;
        ovf          = res_ovf;
        cfg_word     = res_word;
        pll_kbps     = res_pll;
        lp_div_field = res_lp;
    end

    // R1: busy and done are never high together
    p_excl_r1: assert property (@(posedge clk) disable iff (!rst_n)
        !(busy && done));

    // R1: an accepted nonzero request raises busy on the next cycle
    p_start_busy_r1: assert property (@(posedge clk) disable iff (!rst_n)
        (start && !busy && !done && ref_khz != '0) |=> busy);

    // R4: a saturated multiplier shows as 255 in the field
    p_sat_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (done && ovf) |-> cfg_word[7:0] == 8'hFF);

    // R8: a rejected request leaves cleared results
    p_fault_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (done && err) |-> (cfg_word == '0 && pll_kbps == '0 && !ovf));

    // R2: a finished run never carries a zero predivider
    p_pdiv_nz_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (done && !err) |-> cfg_word[12:8] != '0);

    // R6: top range code whenever the rate reaches the top threshold
    p_range_top_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (done && !err && pll_kbps >= PLL_W'(RC3_KBPS)) |-> cfg_word[15:14] == 2'd3);

    // R9: results hold while idle without a request
    p_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (!start && !busy && !done) |=> $stable(cfg_word) && $stable(pll_kbps));

endmodule

// File: tb/test_dsi_pll_calc.sv
module test_dsi_pll_calc;

    localparam int REF_W  = 20;
    localparam int RATE_W = 20;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              start = 1'b0;
    logic [REF_W-1:0]  ref_khz = '0;
    logic [RATE_W-1:0] rate_kbps = '0;
    logic              busy, done, err, ovf;
    logic [15:0]       cfg_word;
    logic [REF_W+7:0]  pll_kbps;
    logic [5:0]        lp_div_field;

    int checks = 0;
    int errors = 0;
    int cycles = 0;

    always #4 clk = ~clk;

    dsi_pll_calc #(.REF_W(REF_W), .RATE_W(RATE_W)) i_dsi_pll_calc (
        .clk(clk), .rst_n(rst_n), .start(start),
        .ref_khz(ref_khz), .rate_kbps(rate_kbps),
        .busy(busy), .done(done), .err(err), .ovf(ovf),
        .cfg_word(cfg_word), .pll_kbps(pll_kbps), .lp_div_field(lp_div_field)
    );

    always @(posedge clk) begin
        cycles <= cycles + 1;
        if (cycles > 190000) begin
            errors = errors + 1;
            $display("FAIL watchdog: run did not finish, actual %0d cycles expected below 190000", cycles);
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    task automatic check(input bit ok, input string req, input longint act, input longint exp);
        checks = checks + 1;
        if (!ok) begin
            errors = errors + 1;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    // expected values from the requirements
    task automatic model(input longint r, input longint q,
                         output longint word, output longint pll,
                         output longint lp, output bit o);
        longint p, m, ms, me, n, rc;
        p = r / 5000;
        if (p < 1) p = 1;
        if (p > 31) p = 31;
        m = (q * p + r - 1) / r;
        o = (m > 255);
        ms = o ? 255 : m;
        me = (ms == 0) ? 1 : ms;
        pll = (r * me) / p;
        if (pll >= 501000) rc = 3;
        else if (pll >= 251000) rc = 2;
        else if (pll >= 126000) rc = 1;
        else rc = 0;
        n = (pll + 79999) / 80000;
        lp = (n - 1) & 63;
        word = (rc << 14) | (p << 8) | ms;
    endtask

    task automatic wait_done(output bit ok);
        ok = 1'b0;
        for (int i = 0; i < 2000; i++) begin
            if (done) begin ok = 1'b1; break; end
            @(negedge clk);
        end
    endtask

    task automatic run(input longint r, input longint q, input bit poke);
        longint ew, ep, el;
        bit eo, ok;
        model(r, q, ew, ep, el, eo);
        @(negedge clk);
        ref_khz   = REF_W'(r);
        rate_kbps = RATE_W'(q);
        start     = 1'b1;
        @(negedge clk);
        start = 1'b0;
        check(busy == 1'b1, "R1 busy after start", longint'(busy), 1);
        if (poke) begin
            repeat (10) @(negedge clk);
            ref_khz   = REF_W'(r / 2 + 7);
            rate_kbps = RATE_W'(q / 3 + 11);
            start     = 1'b1;
            @(negedge clk);
            start = 1'b0;
        end
        wait_done(ok);
        check(ok, "R1 done reached", longint'(ok), 1);
        if (!ok) return;
        check(busy == 1'b0, "R1 busy low at done", longint'(busy), 0);
        check(err == 1'b0, "R8 err cleared on valid run", longint'(err), 0);
        check(cfg_word[12:8] == ew[12:8], poke ? "R9 predivider" : "R2 predivider",
              longint'(cfg_word[12:8]), (ew >> 8) & 31);
        check(cfg_word[7:0] == ew[7:0], "R3 multiplier field", longint'(cfg_word[7:0]), ew & 255);
        check(ovf == eo, "R4 overflow flag", longint'(ovf), longint'(eo));
        check(longint'(pll_kbps) == ep, "R5 pll rate", longint'(pll_kbps), ep);
        check(cfg_word[15:13] == ew[15:13], "R6 range code", longint'(cfg_word[15:13]), (ew >> 13) & 7);
        check(longint'(lp_div_field) == el, "R7 lp divider", longint'(lp_div_field), el);
        @(negedge clk);
        check(done == 1'b0, "R1 done single cycle", longint'(done), 0);
    endtask

    initial begin
        longint refs[10] = '{1, 4999, 5000, 9999, 10000, 154999, 155000, 160000, 1048575, 5010};
        longint rates[6] = '{0, 1, 100000, 480000, 1000000, 1048575};

        repeat (3) @(negedge clk);
        // R10 reset state
        check(busy == 1'b0 && done == 1'b0, "R10 busy/done after reset", longint'({busy, done}), 0);
        check(err == 1'b0 && ovf == 1'b0, "R10 flags after reset", longint'({err, ovf}), 0);
        check(cfg_word == 16'd0 && pll_kbps == '0 && lp_div_field == 6'd0,
              "R10 results after reset", longint'(cfg_word), 0);
        rst_n = 1'b1;
        @(negedge clk);

        // R8 zero reference
        ref_khz = '0; rate_kbps = RATE_W'(300000); start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        check(done == 1'b1 && busy == 1'b0, "R8 fault done next cycle", longint'({done, busy}), 2);
        check(err == 1'b1, "R8 err set", longint'(err), 1);
        check(cfg_word == 16'd0 && pll_kbps == '0 && lp_div_field == 6'd0 && ovf == 1'b0,
              "R8 results cleared", longint'(cfg_word), 0);
        @(negedge clk);
        check(done == 1'b0, "R8 done single cycle", longint'(done), 0);

        // range code and divider boundaries (R6, R7)
        run(5010, 500000, 1'b0);
        run(5010, 495001, 1'b0);
        run(5020, 250000, 1'b0);
        run(6300, 126000, 1'b0);
        run(8000, 80000, 1'b0);
        run(8000, 80001, 1'b0);
        // overflow (R4) and zero multiplier (R5)
        run(1, 1048575, 1'b0);
        run(1048575, 0, 1'b0);

        // R9 start while busy is ignored
        run(40000, 480000, 1'b1);

        // corner references by rates
        foreach (refs[i]) foreach (rates[j]) run(refs[i], rates[j], 1'b0);
        // sweep over the reference range
        for (int k = 0; k < 40; k++) begin
            for (int j = 0; j < 6; j++) run(1000 + longint'(k) * 26111, rates[j], 1'b0);
        end

        // after a fault, a valid run clears err (R8)
        ref_khz = '0; start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        @(negedge clk);
        run(20000, 300000, 1'b0);

        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule